// File: doc/BRIEF.md
# Debug Register Write-Permission Filter

This block sits in front of a bank of on-chip debug registers and screens every write aimed at it. Writes arrive from two requesters: an external JTAG debugger and the CPU while it runs a monitor-mode handler. For each write the filter decodes the target register and applies that register's permission rule. The rule depends on which requester is writing and on live state: whether the CPU is running, the enable bit of every trace channel and every breakpoint/watchpoint comparator, and the debug-mode status bit.

A write that passes raises one write enable for the target register in the same cycle and forwards the winner's data. A write that fails is dropped with no response to the requester. Each requester has a sticky rejected flag. The flags exist so that dropped writes can be seen from outside, and they never feed back into any permission decision. The register count follows three parameters: trace channels, program-counter comparators and data comparators. Addresses are laid out linearly from them.

Top module: `dbgw_filter`

## Requirements
- R1: Address map, with NT trace channels, NP PC comparators and ND data comparators:
  - 0 development control
  - 1 watchpoint trigger
  - 2 trace control
  - 3 PC comparator control
  - 4 data comparator control
  - 5 comparator data
  - 6 debug instruction
  - 7 debug program counter
  - 8+n trace start address for channel n
  - 8+NT+n trace end address for channel n
  - 8+2NT+n PC comparator address n
  - 8+2NT+NP+n data comparator address n

  A granted write raises only bit `reg_we[addr]` in the same cycle, and `reg_wdata` carries that requester's data. With no granted write, `reg_we` is all zero and `reg_wdata` is zero.
- R2: JTAG writes to development control, watchpoint trigger, trace control and both comparator control registers are granted while the CPU runs, whatever the enable state.
- R3: A trace start or end address write for channel n is granted, for either requester, only while `trc_en[n]` is 0. This holds whether the CPU is running or halted.
- R4: While the CPU runs, a JTAG write is treated as follows:
  - PC comparator address n is granted only if `pb_en[n]` is 0.
  - Data comparator address n is granted only if `db_en[n]` is 0.
  - Comparator data is granted only if all `db_en` bits are 0.
- R5: While the CPU runs, JTAG writes to the debug instruction and debug program counter registers are refused.
- R6: While the CPU is halted (`cpu_running`=0), JTAG writes to every mapped register except the trace address registers are granted.
- R7: CPU writes are refused while `mon_mode` is 0. A CPU write to either comparator control register is granted only when `dm_bit` is 1.
- R8: A CPU write to a comparator address or comparator data register is granted when `dm_bit` is 1, or when its comparator is disabled (all data comparators, for comparator data).
- R9: CPU writes in monitor mode to development control, watchpoint trigger and trace control are granted. CPU writes to debug instruction and debug program counter are refused.
- R10: When both requesters present a write in the same cycle, only the JTAG write is evaluated and the CPU write is dropped.
- R11: A write to an address at or above the register count is refused.
- R12: `jtg_rej_q` and `cpu_rej_q` are 0 after reset. Each goes to 1 on the clock edge after that requester presents a refused write. Each then stays at 1 until reset, and it never blocks a later grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_running | input | 1 | 1 while the CPU executes, 0 while halted |
| mon_mode | input | 1 | 1 while the CPU runs its monitor-mode handler |
| dm_bit | input | 1 | Debug-mode status bit |
| trc_en | input | NTRC | Trace channel enable bits |
| pb_en | input | NPB | PC comparator enable bits |
| db_en | input | NDB | Data comparator enable bits |
| jtg_vld | input | 1 | JTAG write strobe, one cycle |
| jtg_addr | input | AW | JTAG target register index |
| jtg_data | input | DW | JTAG write data |
| cpu_vld | input | 1 | CPU write strobe, one cycle |
| cpu_addr | input | AW | CPU target register index |
| cpu_data | input | DW | CPU write data |
| reg_we | output | NREG | One write enable per debug register |
| reg_wdata | output | DW | Data for the granted write |
| jtg_rej_q | output | 1 | Sticky: a JTAG write was refused |
| cpu_rej_q | output | 1 | Sticky: a CPU write was refused |

## Verification
The bench builds the filter with two trace channels, two PC comparators and three data comparators, which gives 17 registers behind a 5-bit address. Three data comparators make the comparator-data rule depend on an enable bit other than bit 0, so the bench can check the all-disabled test for real. The 17-entry map also leaves addresses 17 to 31 unmapped, which brings the out-of-range refusal within reach; a power-of-two map would hide it. The vector table sweeps each register class against both requesters, running and halted, and set and clear enables and debug mode.

// File: rtl/dbgw_pkg.sv
package dbgw_pkg;

    // Fixed part of the register map; the parameter-sized groups follow at 8.
    localparam int A_DEVCTL = 0;
    localparam int A_WPTRIG = 1;
    localparam int A_TRCCTL = 2;
    localparam int A_PBWC   = 3;
    localparam int A_DBWC   = 4;
    localparam int A_BWD    = 5;
    localparam int A_DINST  = 6;
    localparam int A_DPC    = 7;
    localparam int A_GROUPS = 8;

    typedef enum logic [3:0] {
        C_DEVCTL,
        C_WPTRIG,
        C_TRCCTL,
        C_PBWC,
        C_DBWC,
        C_BWD,
        C_DINST,
        C_DPC,
        C_TSA,
        C_TEA,
        C_PBWA,
        C_DBWA
    } cls_e;

    typedef struct packed {
        logic jrej;
        logic crej;
    } flt_st_t;

endpackage

// File: rtl/dbgw_decode.sv
module dbgw_decode
    import dbgw_pkg::*;
#(
    parameter int NTRC = 2,
    parameter int NPB  = 2,
    parameter int NDB  = 2,
    parameter int AW   = 5
) (
    input  logic [AW-1:0] addr,
    output logic          hit,
    output cls_e          cls,
    output logic [AW-1:0] idx
);
    localparam int B_TSA  = A_GROUPS;
    localparam int B_TEA  = B_TSA + NTRC;
    localparam int B_PBWA = B_TEA + NTRC;
    localparam int B_DBWA = B_PBWA + NPB;
    localparam int NREG   = B_DBWA + NDB;

    logic [31:0] a;

    always_comb begin
        a   = 32'(addr);
        hit = (a < 32'(NREG));
        cls = C_DEVCTL;
        idx = '0;
        if (a >= 32'(B_DBWA)) begin
            cls = C_DBWA;
            idx = AW'(a - 32'(B_DBWA));
        end else if (a >= 32'(B_PBWA)) begin
            cls = C_PBWA;
            idx = AW'(a - 32'(B_PBWA));
        end else if (a >= 32'(B_TEA)) begin
            cls = C_TEA;
            idx = AW'(a - 32'(B_TEA));
        end else if (a >= 32'(B_TSA)) begin
            cls = C_TSA;
            idx = AW'(a - 32'(B_TSA));
        end else begin
            case (a)
                32'(A_DEVCTL): cls = C_DEVCTL;
                32'(A_WPTRIG): cls = C_WPTRIG;
                32'(A_TRCCTL): cls = C_TRCCTL;
                32'(A_PBWC):   cls = C_PBWC;
                32'(A_DBWC):   cls = C_DBWC;
                32'(A_BWD):    cls = C_BWD;
                32'(A_DINST):  cls = C_DINST;
                default:       cls = C_DPC;
            endcase
        end
    end

endmodule

// File: rtl/dbgw_rule.sv
module dbgw_rule
    import dbgw_pkg::*;
#(
    parameter int NTRC   = 2,
    parameter int NPB    = 2,
    parameter int NDB    = 2,
    parameter int AW     = 5,
    parameter bit IS_CPU = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hit,
    input  cls_e            cls,
    input  logic [AW-1:0]   idx,
    input  logic            cpu_running,
    input  logic            mon_mode,
    input  logic            dm_bit,
    input  logic [NTRC-1:0] trc_en,
    input  logic [NPB-1:0]  pb_en,
    input  logic [NDB-1:0]  db_en,
    output logic            allow
);
    logic trc_sel, pb_sel, db_sel;
    logic res_free;
    logic rule;

    // Pick the enable bit of the resource the indexed register configures.
    always_comb begin
        trc_sel = 1'b0;
        pb_sel  = 1'b0;
        db_sel  = 1'b0;
        for (int i = 0; i < NTRC; i++) if (idx == AW'(i)) trc_sel = trc_en[i];
        for (int i = 0; i < NPB; i++)  if (idx == AW'(i)) pb_sel  = pb_en[i];
        for (int i = 0; i < NDB; i++)  if (idx == AW'(i)) db_sel  = db_en[i];
    end

    always_comb begin
        case (cls)
            C_TSA, C_TEA: res_free = ~trc_sel;
            C_PBWA:       res_free = ~pb_sel;
            C_DBWA:       res_free = ~db_sel;
            C_BWD:        res_free = ~(|db_en);
            default:      res_free = 1'b1;
        endcase
    end

    generate
        if (IS_CPU) begin : g_cpu
            always_comb begin
                case (cls)
                    C_DEVCTL, C_WPTRIG, C_TRCCTL: rule = 1'b1;
                    C_PBWC, C_DBWC:               rule = dm_bit;
                    C_TSA, C_TEA:                 rule = res_free;
                    C_PBWA, C_DBWA, C_BWD:        rule = dm_bit | res_free;
                    default:                      rule = 1'b0;
                endcase
                rule = rule & mon_mode;
            end
        end else begin : g_jtag
            always_comb begin
                if (cls == C_TSA || cls == C_TEA) begin
                    rule = res_free;
                end else if (!cpu_running) begin
                    rule = 1'b1;
                end else begin
                    case (cls)
                        C_DEVCTL, C_WPTRIG, C_TRCCTL,
                        C_PBWC, C_DBWC:               rule = 1'b1;
                        C_PBWA, C_DBWA, C_BWD:        rule = res_free;
                        default:                      rule = 1'b0;
                    endcase
                end
            end
        end
    endgenerate

    assign allow = hit & rule;

    // Trace address registers stay locked while their channel is enabled.
    assert_trace_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((cls == C_TSA || cls == C_TEA) && trc_sel) |-> !allow);

    // Unmapped addresses never pass.
    assert_unmapped_refused_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> !allow);

    generate
        if (IS_CPU) begin : g_cpu_chk
            assert_cpu_needs_monitor_R7: assert property (@(posedge clk) disable iff (!rst_n)
                !mon_mode |-> !allow);
            assert_cpu_ctl_needs_dm_R7: assert property (@(posedge clk) disable iff (!rst_n)
                ((cls == C_PBWC || cls == C_DBWC) && !dm_bit) |-> !allow);
        end else begin : g_jtag_chk
            assert_jtag_exec_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (cpu_running && (cls == C_DINST || cls == C_DPC)) |-> !allow);
        end
    endgenerate

endmodule

// File: rtl/dbgw_filter.sv
module dbgw_filter
    import dbgw_pkg::*;
#(
    parameter  int NTRC = 2,
    parameter  int NPB  = 2,
    parameter  int NDB  = 2,
    parameter  int DW   = 32,
    localparam int NREG = A_GROUPS + 2 * NTRC + NPB + NDB,
    localparam int AW   = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cpu_running,
    input  logic            mon_mode,
    input  logic            dm_bit,
    input  logic [NTRC-1:0] trc_en,
    input  logic [NPB-1:0]  pb_en,
    input  logic [NDB-1:0]  db_en,
    input  logic            jtg_vld,
    input  logic [AW-1:0]   jtg_addr,
    input  logic [DW-1:0]   jtg_data,
    input  logic            cpu_vld,
    input  logic [AW-1:0]   cpu_addr,
    input  logic [DW-1:0]   cpu_data,
    output logic [NREG-1:0] reg_we,
    output logic [DW-1:0]   reg_wdata,
    output logic            jtg_rej_q,
    output logic            cpu_rej_q
);
    localparam int NRQ = 2;

    logic [AW-1:0] r_addr [NRQ];
    logic [NRQ-1:0] r_hit;
    logic [NRQ-1:0] r_allow;
    cls_e           r_cls [NRQ];
    logic [AW-1:0]  r_idx [NRQ];

    assign r_addr[0] = jtg_addr;
    assign r_addr[1] = cpu_addr;

    generate
        for (genvar r = 0; r < NRQ; r++) begin : g_req
            dbgw_decode #(.NTRC(NTRC), .NPB(NPB), .NDB(NDB), .AW(AW)) u_dec (
                .addr (r_addr[r]),
                .hit  (r_hit[r]),
                .cls  (r_cls[r]),
                .idx  (r_idx[r])
            );
            dbgw_rule #(.NTRC(NTRC), .NPB(NPB), .NDB(NDB), .AW(AW),
                        .IS_CPU(r == 1)) u_rule (
                .clk         (clk),
                .rst_n       (rst_n),
                .hit         (r_hit[r]),
                .cls         (r_cls[r]),
                .idx         (r_idx[r]),
                .cpu_running (cpu_running),
                .mon_mode    (mon_mode),
                .dm_bit      (dm_bit),
                .trc_en      (trc_en),
                .pb_en       (pb_en),
                .db_en       (db_en),
                .allow       (r_allow[r])
            );
        end
    endgenerate

    logic    j_ok, c_ok;
    flt_st_t st_d, st_q;

    // JTAG has priority; a CPU write in the same cycle is dropped.
    always_comb begin
        j_ok      = jtg_vld & r_allow[0];
        c_ok      = cpu_vld & r_allow[1] & ~jtg_vld;
        reg_we    = '0;
        reg_wdata = '0;
        if (j_ok) begin
            reg_we    = NREG'(1) << jtg_addr;
            reg_wdata = jtg_data;
        end else if (c_ok) begin
            reg_we    = NREG'(1) << cpu_addr;
            reg_wdata = cpu_data;
        end
        st_d      = st_q;
        st_d.jrej = st_q.jrej | (jtg_vld & ~j_ok);
        st_d.crej = st_q.crej | (cpu_vld & ~c_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign jtg_rej_q = st_q.jrej;
    assign cpu_rej_q = st_q.crej;

    assert_we_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_we));

    assert_we_needs_request_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!jtg_vld && !cpu_vld) |-> (reg_we == '0));

    assert_jtag_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (jtg_vld && cpu_vld && (reg_we != '0)) |-> (reg_wdata == jtg_data));

    assert_jrej_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        jtg_rej_q |=> jtg_rej_q);

    assert_crej_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rej_q |=> cpu_rej_q);

    assert_jrej_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (jtg_vld && reg_we == '0) |=> jtg_rej_q);

endmodule

// File: tb/dbgw_filter_bench.sv
`timescale 1ns/1ps
module dbgw_filter_bench;
    localparam int NTRC = 2;
    localparam int NPB  = 2;
    localparam int NDB  = 3;
    localparam int DW   = 32;
    localparam int NREG = 17;
    localparam int AW   = 5;
    localparam logic [4:0] NONE = 5'd31;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cpu_running = 1'b0, mon_mode = 1'b0, dm_bit = 1'b0;
    logic [NTRC-1:0] trc_en = '0;
    logic [NPB-1:0]  pb_en = '0;
    logic [NDB-1:0]  db_en = '0;
    logic            jtg_vld = 1'b0, cpu_vld = 1'b0;
    logic [AW-1:0]   jtg_addr = '0, cpu_addr = '0;
    logic [DW-1:0]   jtg_data = '0, cpu_data = '0;
    logic [NREG-1:0] reg_we;
    logic [DW-1:0]   reg_wdata;
    logic            jtg_rej_q, cpu_rej_q;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    dbgw_filter #(.NTRC(NTRC), .NPB(NPB), .NDB(NDB), .DW(DW)) u_dbgw_filter (
        .clk(clk), .rst_n(rst_n), .cpu_running(cpu_running), .mon_mode(mon_mode),
        .dm_bit(dm_bit), .trc_en(trc_en), .pb_en(pb_en), .db_en(db_en),
        .jtg_vld(jtg_vld), .jtg_addr(jtg_addr), .jtg_data(jtg_data),
        .cpu_vld(cpu_vld), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .reg_we(reg_we), .reg_wdata(reg_wdata),
        .jtg_rej_q(jtg_rej_q), .cpu_rej_q(cpu_rej_q)
    );

    typedef struct packed {
        logic       run;
        logic       mon;
        logic       dm;
        logic [1:0] trc;
        logic [1:0] pbe;
        logic [2:0] dbe;
        logic       jv;
        logic [4:0] ja;
        logic       cv;
        logic [4:0] ca;
        logic [4:0] exp;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 29;
    //                  run  mon  dm   trc    pbe    dbe     jv   ja     cv   ca     exp    rq
    localparam vec_t VT [NV] = '{
        '{1'b1,1'b0,1'b0,2'b00,2'b00,3'b000,1'b1,5'd0, 1'b0,5'd0, 5'd0, 4'd2},  // R2 devctl
        '{1'b1,1'b0,1'b0,2'b00,2'b11,3'b000,1'b1,5'd3, 1'b0,5'd0, 5'd3, 4'd2},  // R2 pc ctl, enabled
        '{1'b1,1'b0,1'b0,2'b11,2'b00,3'b000,1'b1,5'd2, 1'b0,5'd0, 5'd2, 4'd2},  // R2 trace ctl
        '{1'b1,1'b0,1'b0,2'b01,2'b00,3'b000,1'b1,5'd8, 1'b0,5'd0, NONE, 4'd3},  // R3 start ch0 on
        '{1'b1,1'b0,1'b0,2'b01,2'b00,3'b000,1'b1,5'd9, 1'b0,5'd0, 5'd9, 4'd3},  // R3 start ch1 off
        '{1'b0,1'b0,1'b0,2'b01,2'b00,3'b000,1'b1,5'd10,1'b0,5'd0, NONE, 4'd3},  // R3 halted still locked
        '{1'b1,1'b0,1'b0,2'b00,2'b01,3'b000,1'b1,5'd13,1'b0,5'd0, 5'd13,4'd4},  // R4 pc addr1 off
        '{1'b1,1'b0,1'b0,2'b00,2'b01,3'b000,1'b1,5'd12,1'b0,5'd0, NONE, 4'd4},  // R4 pc addr0 on
        '{1'b1,1'b0,1'b0,2'b00,2'b00,3'b100,1'b1,5'd5, 1'b0,5'd0, NONE, 4'd4},  // R4 data reg, db2 on
        '{1'b1,1'b0,1'b0,2'b00,2'b00,3'b011,1'b1,5'd16,1'b0,5'd0, 5'd16,4'd4},  // R4 data addr2 off
        '{1'b1,1'b0,1'b0,2'b00,2'b00,3'b000,1'b1,5'd6, 1'b0,5'd0, NONE, 4'd5},  // R5 dinst running
        '{1'b1,1'b0,1'b0,2'b00,2'b00,3'b000,1'b1,5'd7, 1'b0,5'd0, NONE, 4'd5},  // R5 dpc running
        '{1'b0,1'b0,1'b0,2'b00,2'b00,3'b000,1'b1,5'd6, 1'b0,5'd0, 5'd6, 4'd6},  // R6 dinst halted
        '{1'b0,1'b0,1'b0,2'b00,2'b11,3'b000,1'b1,5'd12,1'b0,5'd0, 5'd12,4'd6},  // R6 pc addr halted
        '{1'b1,1'b0,1'b1,2'b00,2'b00,3'b000,1'b0,5'd0, 1'b1,5'd0, NONE, 4'd7},  // R7 no monitor
        '{1'b1,1'b1,1'b0,2'b00,2'b00,3'b000,1'b0,5'd0, 1'b1,5'd3, NONE, 4'd7},  // R7 ctl without dm
        '{1'b1,1'b1,1'b1,2'b00,2'b00,3'b000,1'b0,5'd0, 1'b1,5'd4, 5'd4, 4'd7},  // R7 ctl with dm
        '{1'b1,1'b1,1'b0,2'b00,2'b00,3'b000,1'b0,5'd0, 1'b1,5'd14,5'd14,4'd8},  // R8 disabled, no dm
        '{1'b1,1'b1,1'b0,2'b00,2'b00,3'b010,1'b0,5'd0, 1'b1,5'd15,NONE, 4'd8},  // R8 enabled, no dm
        '{1'b1,1'b1,1'b1,2'b00,2'b00,3'b010,1'b0,5'd0, 1'b1,5'd15,5'd15,4'd8},  // R8 enabled, dm
        '{1'b1,1'b1,1'b0,2'b00,2'b00,3'b001,1'b0,5'd0, 1'b1,5'd5, NONE, 4'd8},  // R8 data reg locked
        '{1'b1,1'b1,1'b0,2'b00,2'b00,3'b000,1'b0,5'd0, 1'b1,5'd1, 5'd1, 4'd9},  // R9 wptrig
        '{1'b1,1'b1,1'b1,2'b00,2'b00,3'b000,1'b0,5'd0, 1'b1,5'd6, NONE, 4'd9},  // R9 dinst
        '{1'b1,1'b1,1'b1,2'b00,2'b00,3'b000,1'b0,5'd0, 1'b1,5'd7, NONE, 4'd9},  // R9 dpc
        '{1'b1,1'b1,1'b0,2'b00,2'b00,3'b000,1'b1,5'd1, 1'b1,5'd2, 5'd1, 4'd10}, // R10 jtag wins
        '{1'b1,1'b1,1'b0,2'b00,2'b00,3'b000,1'b1,5'd6, 1'b1,5'd2, NONE, 4'd10}, // R10 cpu dropped
        '{1'b0,1'b0,1'b0,2'b00,2'b00,3'b000,1'b1,5'd20,1'b0,5'd0, NONE, 4'd11}, // R11 jtag unmapped
        '{1'b1,1'b1,1'b1,2'b00,2'b00,3'b000,1'b0,5'd0, 1'b1,5'd31,NONE, 4'd11}, // R11 cpu unmapped
        '{1'b1,1'b1,1'b1,2'b10,2'b00,3'b000,1'b0,5'd0, 1'b1,5'd11,NONE, 4'd3}   // R3 cpu end ch1 on
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        jtg_vld = 1'b0;
        cpu_vld = 1'b0;
    endtask

    initial begin : watchdog
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [NREG-1:0] exp_we;
        logic [DW-1:0]   exp_d;
        repeat (3) @(negedge clk);
        // R12 / R1 reset state
        check("R12 jrej at reset", 64'(jtg_rej_q), 64'd0);
        check("R12 crej at reset", 64'(cpu_rej_q), 64'd0);
        check("R1 idle enables", 64'(reg_we), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            cpu_running = VT[i].run;
            mon_mode    = VT[i].mon;
            dm_bit      = VT[i].dm;
            trc_en      = VT[i].trc;
            pb_en       = VT[i].pbe;
            db_en       = VT[i].dbe;
            jtg_vld     = VT[i].jv;
            jtg_addr    = VT[i].ja;
            jtg_data    = 32'hA000_0000 | 32'(i);
            cpu_vld     = VT[i].cv;
            cpu_addr    = VT[i].ca;
            cpu_data    = 32'hC000_0000 | 32'(i);
            #1;
            exp_we = (VT[i].exp == NONE) ? '0 : (NREG'(1) << VT[i].exp);
            exp_d  = (VT[i].exp == NONE) ? '0 :
                     ((VT[i].jv && VT[i].ja == VT[i].exp) ? jtg_data : cpu_data);
            check($sformatf("R%0d vector %0d enables", VT[i].rq, i), 64'(reg_we), 64'(exp_we));
            check($sformatf("R1 vector %0d data", i), 64'(reg_wdata), 64'(exp_d));
            @(negedge clk);
        end
        idle();

        // R12 sticky flags from a clean reset
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        cpu_running = 1'b1; mon_mode = 1'b1; dm_bit = 1'b0;
        trc_en = '0; pb_en = '0; db_en = '0;
        @(negedge clk);
        check("R12 flags cleared by reset", 64'({jtg_rej_q, cpu_rej_q}), 64'd0);
        jtg_vld = 1'b1; jtg_addr = 5'd7; jtg_data = 32'h1111;   // refused: dpc while running
        @(negedge clk);
        idle();
        check("R12 jrej set after refusal", 64'(jtg_rej_q), 64'd1);
        check("R12 crej untouched", 64'(cpu_rej_q), 64'd0);
        repeat (3) @(negedge clk);
        check("R12 jrej holds", 64'(jtg_rej_q), 64'd1);
        // R12 flag does not block a later grant
        jtg_vld = 1'b1; jtg_addr = 5'd0; jtg_data = 32'h2222;
        #1;
        check("R12 grant after rejection", 64'(reg_we), 64'(NREG'(1)));
        @(negedge clk);
        // R10 simultaneous: granted JTAG, CPU dropped and flagged
        jtg_vld = 1'b1; jtg_addr = 5'd1; jtg_data = 32'h3333;
        cpu_vld = 1'b1; cpu_addr = 5'd2; cpu_data = 32'h4444;
        #1;
        check("R10 jtag data forwarded", 64'(reg_wdata), 64'h3333);
        @(negedge clk);
        idle();
        check("R10 cpu drop flagged", 64'(cpu_rej_q), 64'd1);
        // R11 top of the address range
        jtg_vld = 1'b1; jtg_addr = 5'd17; cpu_running = 1'b0;
        #1;
        check("R11 first unmapped address", 64'(reg_we), 64'd0);
        jtg_addr = 5'd16;
        #1;
        check("R6 last mapped address halted", 64'(reg_we), 64'(NREG'(1) << 16));
        @(negedge clk);
        idle();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule